// File: doc/BRIEF.md
# Nested Loop End-Point Flag Generator

This block steps through a schedule of up to three nested loops, x innermost, then y, then z. Each loop has its own programmable extent. For every element it presents a linear element index and a 4-bit end-point field. Each bit of that field says that one of the loops has reached its last value, and one bit marks the final element of the whole schedule. A consumer uses these flags to branch out of inner loops without recomputing loop bounds.

A one-cycle start pulse loads the three extents and the record option. The block then offers elements one at a time on a valid/ready handshake and moves to the next element only when the consumer takes the current one. After the final element has been accepted, the counters are back at zero and a done flag stays high until the next start.

Top module: `nest_loop_flagger`

## Requirements
- R1: After reset, out_valid_o and done_o are low and idx_o is 0.
- R2: A start pulse loads the extents. Each extent is given as extent minus one in a CNT_W-bit field, so the default of 6 bits covers extents 1 to 64. One cycle after the start pulse, out_valid_o is high, done_o is low and element 0 is presented. A start overrides any schedule in progress.
- R3: Elements are issued with x varying fastest, then y, then z. The index is x + y·X + z·X·Y, where X, Y and Z are the extents.
- R4: Flag bit 0 is high exactly on elements where x equals X-1.
- R5: Flag bit 1 is high exactly on elements where y equals Y-1.
- R6: Flag bit 2 is high exactly on elements where z equals Z-1.
- R7: Flag bit 3 is high only on the final element of the schedule, where x, y and z are all at their last values.
- R8: When the record option was low at start, flags_o is 0 for the whole schedule and the indices are unchanged.
- R9: While out_valid_o is high and out_ready_i is low, idx_o, flags_o and out_valid_o hold their values.
- R10: When the final element is accepted, out_valid_o falls and done_o rises on the next cycle. done_o then stays high, with idx_o at 0, until the next start.
- R11: A loop with an extent of 1 has its flag bit high on every element.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Loads the extents and restarts the schedule |
| xlast_i | input | CNT_W | Inner extent minus one |
| ylast_i | input | CNT_W | Middle extent minus one |
| zlast_i | input | CNT_W | Outer extent minus one |
| rec_en_i | input | 1 | Record option; enables the flag field, sampled at start |
| out_ready_i | input | 1 | Consumer accepts the current element |
| out_valid_o | output | 1 | An element is presented |
| idx_o | output | 3·CNT_W | Linear element index |
| flags_o | output | 4 | Bit 0: x end, bit 1: y end, bit 2: z end, bit 3: final element |
| done_o | output | 1 | Schedule complete, held until the next start |

## Verification
Element 0 is due one clock after the start pulse. Each following element is due one clock after a cycle in which valid and ready were both high, and done is due one clock after the final element is accepted. The bench drives inputs on the falling edge. On that same falling edge it advances a behavioural model of the x, y and z counters whenever the driven ready meets a valid element. It then compares every output on the next falling edge, which falls after exactly one rising edge. Ready is driven in several patterns: always high, alternating and pseudo-random. The stall cycles therefore check the hold rule in the same pass.

// File: rtl/loopgen_pkg.sv
package loopgen_pkg;

   localparam int NUM_LOOPS = 3;
   localparam int FLAG_W    = NUM_LOOPS + 1;

   typedef struct packed {
      logic final_elem;
      logic z_end;
      logic y_end;
      logic x_end;
   } endflags_t;

   function automatic endflags_t make_flags(input logic [NUM_LOOPS-1:0] at_last,
                                            input logic rec);
      endflags_t f;
      f.x_end      = rec & at_last[0];
      f.y_end      = rec & at_last[1];
      f.z_end      = rec & at_last[2];
      f.final_elem = rec & (&at_last);
      return f;
   endfunction

endpackage

// File: rtl/loopgen_counter.sv
module loopgen_counter #(
   parameter int CNT_W = 6
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             clr_i,
   input  logic             step_i,
   input  logic [CNT_W-1:0] last_i,
   output logic [CNT_W-1:0] cnt_o,
   output logic             at_last_o,
   output logic             carry_o
);

   logic [CNT_W-1:0] cnt_q;

   assign at_last_o = (cnt_q == last_i);
   assign carry_o   = step_i & at_last_o;
   assign cnt_o     = cnt_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         cnt_q <= '0;
      else if (clr_i)
         cnt_q <= '0;
      else if (step_i)
         cnt_q <= at_last_o ? '0 : cnt_q + 1'b1;
   end

   // R3: counter never passes its last value
   p_cnt_in_range_r3: assert property (@(posedge clk) disable iff (!rst_n)
      cnt_q <= last_i);

   // R3: stepping at the last value restarts at zero
   p_cnt_wrap_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (step_i && at_last_o && !clr_i) |=> (cnt_q == '0));

endmodule

// File: rtl/loopgen_index.sv
module loopgen_index #(
   parameter int CNT_W = 6,
   parameter int IDX_W = 3 * CNT_W
) (
   input  logic [CNT_W-1:0] x_i,
   input  logic [CNT_W-1:0] y_i,
   input  logic [CNT_W-1:0] z_i,
   input  logic [CNT_W:0]   xext_i,
   input  logic [IDX_W-1:0] plane_i,
   output logic [IDX_W-1:0] idx_o
);

   logic [IDX_W-1:0] row_term;
   logic [IDX_W-1:0] plane_term;

   always_comb begin
      row_term   = IDX_W'(y_i) * IDX_W'(xext_i);
      plane_term = IDX_W'(z_i) * plane_i;
      idx_o      = IDX_W'(x_i) + row_term + plane_term;
   end

endmodule

// File: rtl/nest_loop_flagger.sv
module nest_loop_flagger
   import loopgen_pkg::*;
#(
   parameter int CNT_W = 6,
   localparam int IDX_W = 3 * CNT_W
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             start_i,
   input  logic [CNT_W-1:0] xlast_i,
   input  logic [CNT_W-1:0] ylast_i,
   input  logic [CNT_W-1:0] zlast_i,
   input  logic             rec_en_i,
   input  logic             out_ready_i,
   output logic             out_valid_o,
   output logic [IDX_W-1:0] idx_o,
   output logic [3:0]       flags_o,
   output logic             done_o
);

   generate
      if (CNT_W < 1 || CNT_W > 10) begin : g_bad_width
         $error("nest_loop_flagger: CNT_W must lie in 1..10");
      end
   endgenerate

   logic [NUM_LOOPS-1:0][CNT_W-1:0] last_q;
   logic [NUM_LOOPS-1:0][CNT_W-1:0] cnt;
   logic [NUM_LOOPS-1:0]            at_last;
   logic [NUM_LOOPS-1:0]            carry;
   logic [NUM_LOOPS-1:0]            step;
   logic [IDX_W-1:0]                plane_q;
   logic                            rec_q;
   logic                            valid_q;
   logic                            done_q;
   logic                            adv;
   logic                            final_now;
   endflags_t                       flags;

   assign adv       = valid_q & out_ready_i & ~start_i;
   assign final_now = &at_last;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         last_q  <= '0;
         plane_q <= '0;
         rec_q   <= 1'b0;
         valid_q <= 1'b0;
         done_q  <= 1'b0;
      end else if (start_i) begin
         last_q[0] <= xlast_i;
         last_q[1] <= ylast_i;
         last_q[2] <= zlast_i;
         plane_q   <= IDX_W'(({1'b0, xlast_i} + 1'b1) * ({1'b0, ylast_i} + 1'b1));
         rec_q     <= rec_en_i;
         valid_q   <= 1'b1;
         done_q    <= 1'b0;
      end else if (adv && final_now) begin
         valid_q <= 1'b0;
         done_q  <= 1'b1;
      end
   end

   genvar g;
   generate
      for (g = 0; g < NUM_LOOPS; g++) begin : g_loop
         if (g == 0) begin : g_inner
            assign step[g] = adv;
         end else begin : g_outer
            assign step[g] = carry[g-1];
         end
         loopgen_counter #(.CNT_W(CNT_W)) u_cnt (
            .clk       (clk),
            .rst_n     (rst_n),
            .clr_i     (start_i),
            .step_i    (step[g]),
            .last_i    (last_q[g]),
            .cnt_o     (cnt[g]),
            .at_last_o (at_last[g]),
            .carry_o   (carry[g])
         );
      end
   endgenerate

   loopgen_index #(.CNT_W(CNT_W), .IDX_W(IDX_W)) u_index (
      .x_i     (cnt[0]),
      .y_i     (cnt[1]),
      .z_i     (cnt[2]),
      .xext_i  ({1'b0, last_q[0]} + 1'b1),
      .plane_i (plane_q),
      .idx_o   (idx_o)
   );

   assign flags       = make_flags(at_last, rec_q & valid_q);
   assign flags_o     = flags;
   assign out_valid_o = valid_q;
   assign done_o      = done_q;

   p_start_r2: assert property (@(posedge clk) disable iff (!rst_n)
      start_i |=> (out_valid_o && !done_o && idx_o == '0));

   p_final_r7: assert property (@(posedge clk) disable iff (!rst_n)
      flags_o[3] |-> (flags_o[2:0] == 3'b111));

   p_mute_r8: assert property (@(posedge clk) disable iff (!rst_n)
      !rec_q |-> (flags_o == 4'b0000));

   p_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (out_valid_o && !out_ready_i && !start_i) |=>
         (out_valid_o && $stable(idx_o) && $stable(flags_o)));

   p_done_excl_r10: assert property (@(posedge clk) disable iff (!rst_n)
      done_o |-> !out_valid_o);

   p_finish_r10: assert property (@(posedge clk) disable iff (!rst_n)
      (out_valid_o && out_ready_i && final_now && !start_i) |=> (done_o && idx_o == '0));

endmodule

// File: tb/nest_loop_flagger_bench.sv
module nest_loop_flagger_bench;

   localparam int CNT_W = 6;
   localparam int IDX_W = 3 * CNT_W;

   logic             clk = 1'b0;
   logic             rst_n = 1'b0;
   logic             start_i = 1'b0;
   logic [CNT_W-1:0] xlast_i = '0;
   logic [CNT_W-1:0] ylast_i = '0;
   logic [CNT_W-1:0] zlast_i = '0;
   logic             rec_en_i = 1'b0;
   logic             out_ready_i = 1'b0;
   logic             out_valid_o;
   logic [IDX_W-1:0] idx_o;
   logic [3:0]       flags_o;
   logic             done_o;

   int checks = 0;
   int errors = 0;
   bit finished = 1'b0;

   // behavioural model state
   int  mx, my, mz, xe, ye, ze;
   bit  mvalid = 1'b0, mdone = 1'b0, mrec = 1'b0;
   int  elem_no;
   bit  prev_stall = 1'b0;
   int  prev_idx;
   int unsigned lfsr = 32'h1234_5678;

   always #10 clk = ~clk;   // 50 MHz

   nest_loop_flagger #(.CNT_W(CNT_W)) u_nest_loop_flagger (
      .clk(clk), .rst_n(rst_n), .start_i(start_i),
      .xlast_i(xlast_i), .ylast_i(ylast_i), .zlast_i(zlast_i),
      .rec_en_i(rec_en_i), .out_ready_i(out_ready_i),
      .out_valid_o(out_valid_o), .idx_o(idx_o), .flags_o(flags_o), .done_o(done_o)
   );

   task automatic chk(input bit ok, input string req, input int act, input int exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s: actual=%0d expected=%0d at %0t", req, act, exp, $time);
      end
   endtask

   task automatic compare();
      int eidx;
      logic [3:0] ef;
      chk(out_valid_o == mvalid, "R10 valid", int'(out_valid_o), int'(mvalid));
      chk(done_o == mdone, "R10 done", int'(done_o), int'(mdone));
      if (mvalid) begin
         eidx = mx + my * xe + mz * xe * ye;
         chk(int'(idx_o) == eidx, (elem_no == 0) ? "R2 first index" : "R3 index",
             int'(idx_o), eidx);
         ef = {(mx == xe-1) && (my == ye-1) && (mz == ze-1),
               mz == ze-1, my == ye-1, mx == xe-1};
         if (!mrec) begin
            chk(flags_o == 4'b0000, "R8 flags muted", int'(flags_o), 0);
         end else begin
            chk(flags_o[0] == ef[0], (xe == 1) ? "R11 x flag" : "R4 x flag",
                int'(flags_o[0]), int'(ef[0]));
            chk(flags_o[1] == ef[1], (ye == 1) ? "R11 y flag" : "R5 y flag",
                int'(flags_o[1]), int'(ef[1]));
            chk(flags_o[2] == ef[2], (ze == 1) ? "R11 z flag" : "R6 z flag",
                int'(flags_o[2]), int'(ef[2]));
            chk(flags_o[3] == ef[3], "R7 final flag", int'(flags_o[3]), int'(ef[3]));
         end
         if (prev_stall)
            chk(int'(idx_o) == prev_idx, "R9 hold", int'(idx_o), prev_idx);
      end else if (mdone) begin
         chk(idx_o == '0, "R10 idle index", int'(idx_o), 0);
      end
   endtask

   // rmode: 0 always ready, 1 alternating, 2 pseudo-random
   task automatic run_sched(input int x, input int y, input int z, input bit rec, input int rmode);
      int cyc = 0;
      @(negedge clk);
      start_i = 1'b1; xlast_i = CNT_W'(x-1); ylast_i = CNT_W'(y-1); zlast_i = CNT_W'(z-1);
      rec_en_i = rec; out_ready_i = 1'b0;
      xe = x; ye = y; ze = z; mrec = rec;
      mx = 0; my = 0; mz = 0; mvalid = 1'b1; mdone = 1'b0; elem_no = 0; prev_stall = 1'b0;
      @(negedge clk);
      start_i = 1'b0;
      rec_en_i = ~rec;   // must not matter after start
      while (mvalid) begin
         compare();
         case (rmode)
            0: out_ready_i = 1'b1;
            1: out_ready_i = cyc[0];
            default: begin
               lfsr = lfsr * 32'd1103515245 + 32'd12345;
               out_ready_i = lfsr[16];
            end
         endcase
         cyc++;
         prev_stall = !out_ready_i;
         prev_idx   = int'(idx_o);
         if (out_ready_i) begin
            elem_no++;
            if (mx == xe-1 && my == ye-1 && mz == ze-1) begin
               mvalid = 1'b0; mdone = 1'b1; mx = 0; my = 0; mz = 0;
            end else if (mx != xe-1) mx++;
            else begin
               mx = 0;
               if (my != ye-1) my++;
               else begin my = 0; mz++; end
            end
         end
         @(negedge clk);
      end
      prev_stall = 1'b0;
      for (int i = 0; i < 3; i++) begin
         out_ready_i = i[0];
         compare();
         @(negedge clk);
      end
      out_ready_i = 1'b0;
   endtask

   initial begin
      repeat (3) @(negedge clk);
      // R1 reset state
      chk(out_valid_o == 1'b0, "R1 valid", int'(out_valid_o), 0);
      chk(done_o == 1'b0, "R1 done", int'(done_o), 0);
      chk(idx_o == '0, "R1 index", int'(idx_o), 0);
      rst_n = 1'b1;
      @(negedge clk);
      chk(out_valid_o == 1'b0, "R1 valid after release", int'(out_valid_o), 0);

      run_sched(3, 2, 2, 1'b1, 0);
      run_sched(4, 3, 2, 1'b1, 1);
      run_sched(1, 1, 1, 1'b1, 0);   // R11 single element
      run_sched(1, 3, 1, 1'b1, 2);   // R11 unit x and z
      run_sched(5, 1, 3, 1'b0, 2);   // R8 record off
      run_sched(64, 1, 1, 1'b1, 0);  // full-width extent
      run_sched(7, 5, 3, 1'b1, 2);

      // R2 start overrides a schedule in progress
      @(negedge clk);
      start_i = 1'b1; xlast_i = 6'd3; ylast_i = 6'd3; zlast_i = 6'd3; rec_en_i = 1'b1;
      @(negedge clk);
      start_i = 1'b0; out_ready_i = 1'b1;
      repeat (5) @(negedge clk);
      out_ready_i = 1'b0;
      run_sched(2, 3, 4, 1'b1, 1);

      finished = 1'b1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

   initial begin
      repeat (100000) @(posedge clk);
      if (!finished) begin
         checks++;
         errors++;
         $display("FAIL watchdog: actual=timeout expected=completion");
         $display("Result: errors=%0d of %0d checks", errors, checks);
         $finish;
      end
   end

endmodule